// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This unit sits beside a serial port's register file. It holds the modem control register, which drives the four outgoing handshake pins and the loopback enable. It also holds the modem status register, which tracks the four incoming handshake lines. Each incoming line passes through a two-flop synchronizer. The unit then compares the synchronized value against the state it last stored and records every change in a sticky delta bit. A single change flag tells the interrupt logic that at least one delta is pending. Reading the status register returns its current contents and clears the deltas.

In loopback mode the control outputs are routed back onto the status inputs through a fixed mapping. While loopback is on, the external lines are ignored: the stored line state and the deltas are held. When loopback ends, any difference between the held state and the real lines shows up as deltas.

Both registers sit on a plain single-cycle register port with a write strobe, a read strobe and a combinational read value. There is no stream traffic, so the port has no valid/ready handshake and no back-pressure: the port always accepts an access in the cycle it is presented.

Top module: `mdm_line_unit`

## Requirements
- R1: After reset, reading the control register (offset 4) returns 0x08, reading the status register (offset 6) returns 0xB0, `status_chg` is 0, `aux2_out` is 1, and `dtr_out`, `rts_out`, `aux1_out` and `loop_out` are 0.
- R2: A write to offset 4 stores only data bits 4:0, and reading offset 4 returns them with bits 7:5 as zero. The stored bits map to pins as follows: bit 0 drives `dtr_out`, bit 1 drives `rts_out`, bit 2 drives `aux1_out`, bit 3 drives `aux2_out` and bit 4 drives `loop_out`.
- R3: The status register shows the line state in its upper nibble: bit 7 is DCD, bit 6 is RI, bit 5 is DSR and bit 4 is CTS. A change on an external line reaches the stored state on the third rising clock edge after the change, and not before.
- R4: A change of DCD, DSR or CTS in either direction sets status bit 3, bit 1 or bit 0 respectively. The delta bit stays set until a status read clears it.
- R5: Status bit 2 is set only when RI falls from 1 to 0. A rising RI sets no delta bit.
- R6: A read of offset 6 outside loopback returns the current register value, and bits 3:0 are zero from the next cycle on.
- R7: A delta bit that is set by a line change in the same cycle as a status read stays set after that read.
- R8: `status_chg` is 1 exactly when any of status bits 3:0 is set.
- R9: With loopback on, a status read returns `aux2_out` as DCD, `aux1_out` as RI, `dtr_out` as DSR and `rts_out` as CTS, with bits 3:0 reading zero. External line changes during loopback change neither the read value nor `status_chg`. They appear as deltas once loopback is turned off.
- R10: A write to offset 6 has no effect on the status register, and a read of any offset other than 4 or 6 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a status read clears the deltas |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| cts_in | input | 1 | External clear-to-send line, 1 = asserted |
| dsr_in | input | 1 | External data-set-ready line, 1 = asserted |
| dcd_in | input | 1 | External carrier-detect line, 1 = asserted |
| ri_in | input | 1 | External ring line, 1 = asserted |
| rts_out | output | 1 | Request-to-send pin |
| dtr_out | output | 1 | Data-terminal-ready pin |
| aux1_out | output | 1 | First general-purpose output pin |
| aux2_out | output | 1 | Second general-purpose output pin |
| loop_out | output | 1 | Loopback mode active |
| status_chg | output | 1 | At least one status delta bit is pending |

## Verification
Two things can land on the same clock edge here: a status read that clears the deltas, and a freshly synchronized line change that sets one. The bench sets up this collision on purpose. It leaves one delta pending, toggles a second line, and raises the read strobe two edges later, so the clearing edge is also the third edge of the synchronizer path. The expected result is that the read returns the old line state with the old delta. The next read must then show only the new delta. Loopback entry and exit are checked the same way, against the held state.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  // Line nibble bit positions (upper nibble of the status register)
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;
  localparam int LN_W   = 4;

  // Control register bit positions
  localparam int CT_DTR  = 0;
  localparam int CT_RTS  = 1;
  localparam int CT_AUX1 = 2;
  localparam int CT_AUX2 = 3;
  localparam int CT_LOOP = 4;
  localparam int CT_W    = 5;

  // Reset values
  localparam logic [LN_W-1:0] LN_RST = 4'b1011;   // DCD, DSR, CTS asserted
  localparam logic [CT_W-1:0] CT_RST = 5'b01000;  // only AUX2 set

  // Loopback routing: control outputs seen as status inputs
  function automatic logic [LN_W-1:0] loop_map(input logic [CT_W-1:0] ct);
    logic [LN_W-1:0] m;
    m[LN_DCD] = ct[CT_AUX2];
    m[LN_RI]  = ct[CT_AUX1];
    m[LN_DSR] = ct[CT_DTR];
    m[LN_CTS] = ct[CT_RTS];
    return m;
  endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int                W       = 4,
  parameter int                STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CT_W-1:0] wdata,
  output logic [CT_W-1:0] ctrl_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= CT_RST;
    else if (wr_en) ctrl_q <= wdata;
  end

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_q == $past(wdata)); // R2

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q)); // R2

endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            clr,
  input  logic [LN_W-1:0] lines_in,
  output logic [LN_W-1:0] line_q,
  output logic [LN_W-1:0] delta_q
);

  logic [LN_W-1:0] diff;
  logic [LN_W-1:0] set_bits;

  always_comb begin
    diff = lines_in ^ line_q;
    set_bits = '0;
    set_bits[LN_DCD] = diff[LN_DCD];
    set_bits[LN_DSR] = diff[LN_DSR];
    set_bits[LN_CTS] = diff[LN_CTS];
    set_bits[LN_RI]  = line_q[LN_RI] & ~lines_in[LN_RI];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= LN_RST;
      delta_q <= '0;
    end else if (!hold) begin
      line_q  <= lines_in;
      delta_q <= (clr ? '0 : delta_q) | set_bits;
    end
  end

  AST_RING_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_q[LN_RI]) |-> ($past(line_q[LN_RI]) && !line_q[LN_RI])); // R5

  AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (delta_q[LN_DCD] && !clr) |=> delta_q[LN_DCD]); // R4

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hold && lines_in == line_q) |=> delta_q == '0); // R6

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hold && lines_in[LN_CTS] != line_q[LN_CTS]) |=> delta_q[LN_CTS]); // R7

  AST_LOOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(line_q) && $stable(delta_q))); // R9

endmodule

// File: rtl/mdm_line_unit.sv
module mdm_line_unit
  import mdm_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_OFS    = 4,
  parameter int STAT_OFS    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cts_in,
  input  logic              dsr_in,
  input  logic              dcd_in,
  input  logic              ri_in,
  output logic              rts_out,
  output logic              dtr_out,
  output logic              aux1_out,
  output logic              aux2_out,
  output logic              loop_out,
  output logic              status_chg
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam int                PAD_W  = DATA_W - CT_W;

  logic            sel_ctrl, sel_stat;
  logic            ctrl_wr, stat_clr;
  logic [CT_W-1:0] ctrl_q;
  logic [LN_W-1:0] raw_lines, sync_lines;
  logic [LN_W-1:0] line_q, delta_q;
  logic            unused_wdata_hi;

  assign sel_ctrl = (reg_addr == A_CTRL);
  assign sel_stat = (reg_addr == A_STAT);
  assign ctrl_wr  = reg_wr & sel_ctrl;
  assign stat_clr = reg_rd & sel_stat & ~ctrl_q[CT_LOOP];
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CT_W];

  always_comb begin
    raw_lines         = '0;
    raw_lines[LN_DCD] = dcd_in;
    raw_lines[LN_RI]  = ri_in;
    raw_lines[LN_DSR] = dsr_in;
    raw_lines[LN_CTS] = cts_in;
  end

  mdm_sync #(
    .W       (LN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (LN_RST)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_lines),
    .d_sync  (sync_lines)
  );

  mdm_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .wdata  (reg_wdata[CT_W-1:0]),
    .ctrl_q (ctrl_q)
  );

  mdm_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (ctrl_q[CT_LOOP]),
    .clr      (stat_clr),
    .lines_in (sync_lines),
    .line_q   (line_q),
    .delta_q  (delta_q)
  );

  assign dtr_out    = ctrl_q[CT_DTR];
  assign rts_out    = ctrl_q[CT_RTS];
  assign aux1_out   = ctrl_q[CT_AUX1];
  assign aux2_out   = ctrl_q[CT_AUX2];
  assign loop_out   = ctrl_q[CT_LOOP];
  assign status_chg = |delta_q;

  always_comb begin
    reg_rdata = '0;
    if (sel_ctrl) begin
      reg_rdata = {{PAD_W{1'b0}}, ctrl_q};
    end else if (sel_stat) begin
      if (ctrl_q[CT_LOOP]) reg_rdata = DATA_W'({loop_map(ctrl_q), {LN_W{1'b0}}});
      else                 reg_rdata = DATA_W'({line_q, delta_q});
    end
  end

  AST_LOOP_NO_DELTA_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel_stat && loop_out) |-> reg_rdata[LN_W-1:0] == '0); // R9

  AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel_stat && !reg_rd && loop_out) |=> $stable(delta_q)); // R10

endmodule

// File: tb/sim_mdm_line_unit.sv
`timescale 1ns/100ps
module sim_mdm_line_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cts_in = 1'b1, dsr_in = 1'b1, dcd_in = 1'b1, ri_in = 1'b0;
  logic       rts_out, dtr_out, aux1_out, aux2_out, loop_out, status_chg;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  mdm_line_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cts_in(cts_in), .dsr_in(dsr_in), .dcd_in(dcd_in), .ri_in(ri_in),
    .rts_out(rts_out), .dtr_out(dtr_out), .aux1_out(aux1_out),
    .aux2_out(aux2_out), .loop_out(loop_out), .status_chg(status_chg)
  );

  // Monitor: compares read data just before the rising edge of a read cycle
  always @(negedge clk) begin
    #2;
    if (reg_rd) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard empty: read data %02h unexpected", reg_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (reg_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: read got %02h expected %02h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_rd = 1'b1; reg_addr = a;
    tick(1);
    reg_rd = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", t, act, e);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(3'd4, 8'h08, "R1 control reset");
    rd(3'd6, 8'hB0, "R1 status reset");
    chk(status_chg, 1'b0, "R1 chg reset");
    chk(aux2_out, 1'b1, "R1 aux2 reset");
    chk(dtr_out | rts_out | aux1_out | loop_out, 1'b0, "R1 other pins reset");

    // R2 control register masking and pin mapping
    wr(3'd4, 8'hFF);
    rd(3'd4, 8'h1F, "R2 upper bits dropped");
    chk(loop_out & dtr_out & rts_out & aux1_out & aux2_out, 1'b1, "R2 all pins set");
    wr(3'd4, 8'h03);
    rd(3'd4, 8'h03, "R2 readback");
    chk(dtr_out, 1'b1, "R2 dtr bit0");
    chk(rts_out, 1'b1, "R2 rts bit1");
    chk(aux1_out | aux2_out | loop_out, 1'b0, "R2 others clear");

    // R3/R4 CTS falls: latency and delta
    cts_in = 1'b0;
    tick(2);
    chk(status_chg, 1'b0, "R3 not before third edge");
    tick(1);
    chk(status_chg, 1'b1, "R3 R8 chg on third edge");
    rd(3'd6, 8'hA1, "R4 cts delta");
    rd(3'd6, 8'hA0, "R6 cleared after read");
    chk(status_chg, 1'b0, "R8 chg low after clear");

    // R5 ring edges
    ri_in = 1'b1;
    tick(3);
    chk(status_chg, 1'b0, "R5 rising ring no delta");
    rd(3'd6, 8'hE0, "R5 ring high no delta");
    ri_in = 1'b0;
    tick(3);
    chk(status_chg, 1'b1, "R5 falling ring chg");
    rd(3'd6, 8'hA4, "R5 trailing edge bit");
    rd(3'd6, 8'hA0, "R6 ring delta cleared");

    // R4 DCD and DSR fall together
    dcd_in = 1'b0; dsr_in = 1'b0;
    tick(3);
    rd(3'd6, 8'h0A, "R4 dcd dsr deltas");
    rd(3'd6, 8'h00, "R6 cleared");

    // R7 read collides with a new delta
    cts_in = 1'b1;
    tick(3);
    dsr_in = 1'b1;
    tick(2);
    rd(3'd6, 8'h11, "R7 read at collision edge");
    rd(3'd6, 8'h32, "R7 new delta survives");
    rd(3'd6, 8'h30, "R6 cleared after collision");

    // R10 status write ignored, other offsets read zero
    wr(3'd6, 8'hFF);
    rd(3'd6, 8'h30, "R10 status write ignored");
    rd(3'd0, 8'h00, "R10 other offset zero");
    rd(3'd7, 8'h00, "R10 offset 7 zero");

    // R9 loopback
    wr(3'd4, 8'h1A);
    rd(3'd6, 8'h90, "R9 loop map aux2 rts");
    cts_in = 1'b0; dcd_in = 1'b1;
    tick(3);
    chk(status_chg, 1'b0, "R9 external ignored chg");
    rd(3'd6, 8'h90, "R9 external ignored read");
    wr(3'd4, 8'h15);
    rd(3'd6, 8'h60, "R9 loop map aux1 dtr");
    wr(3'd4, 8'h00);
    tick(2);
    chk(status_chg, 1'b1, "R9 deltas after loop exit");
    rd(3'd6, 8'hA9, "R9 held state then deltas");
    rd(3'd6, 8'hA0, "R6 cleared after loop");

    tick(2);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: %0d reads never observed", exp_q.size());
    end
    summary();
  end

endmodule